// File: doc/BRIEF.md
# Waveform Timer Channel

A single timer channel that counts on a count-enable pulse stream and produces two waveform outputs, A and B. The counter is compared against three programmable values (RA, RB and RC). Compare matches, a selectable external event and a software trigger each apply a configurable set, clear or toggle action to each output. This allows one channel to generate PWM, one-shot pulses or centre-aligned waveforms without processor involvement.

The channel has four count modes. It can count up or up/down, and in either case it can use RC as its period. It can also halt or switch off its own clock when the count reaches RC. Sticky event flags sit under an interrupt mask that has separate set and clear write ports. Reading the status clears the flags. The clock source ahead of the count-enable input and the bus logic around the write ports belong to the surrounding system.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset, the count is 0, both outputs are 0, the status and mask are 0, `irq_o` is 0 and the channel clock is off (status bit 16 = 0).
- R2: The count advances once for each cycle with `cnt_en_i` high, but only while the channel clock is on. `clk_on_i` turns the clock on and `clk_off_i` turns it off. When both are high in the same cycle, `clk_off_i` wins. Status bit 16 shows the clock state.
- R3: Mode register bits [1:0] select the count mode. In mode 0 the counter counts up and wraps from 0xFFFF to 0. Any tick taken at a count of 0xFFFF sets status bit 0 (overflow).
- R4: In mode 1 the counter counts up to 0xFFFF, then counts down to 0, then counts up again. Each turn happens on the tick taken at the end value.
- R5: In mode 2 the counter counts up, and the tick taken at a count equal to RC loads 0 instead.
- R6: In mode 3 the counter counts up to RC, then counts down to 0, then counts up again.
- R7: A trigger loads 0 into the count, sets the direction to up and releases a halt. A trigger is any of: `sync_i`, `sw_trig_i`, or a detected external event while mode bit 8 is set. A trigger takes precedence over the tick in the same cycle.
- R8: A tick taken at a count equal to RA, RB or RC sets status bit 2, 3 or 4 respectively. It also applies the matching output action. Output A uses mode bits [17:16] for RA, [19:18] for RC, [21:20] for the external event and [23:22] for the software trigger. Output B uses bits [25:24] for RB, [27:26] for RC, [29:28] for the external event and [31:30] for the software trigger.
- R9: Every action field uses the encoding 0 = no change, 1 = set, 2 = clear, 3 = toggle.
- R10: When several events with non-zero actions reach one output in the same cycle, only one action applies. The order of precedence is software trigger, then external event, then RC compare, then RA or RB compare.
- R11: Mode bits [7:6] select which bit of `evt_i` is the event source. Mode bits [5:4] select the detected edge: 0 none, 1 rising, 2 falling, 3 both. A detected event sets status bit 7. An edge that is not selected has no effect.
- R12: When mode bit 2 is set, an RC-match tick halts counting until the next trigger. When mode bit 3 is set, an RC-match tick turns the channel clock off.
- R13: `ier_we_i` sets and `idr_we_i` clears the mask bits given by `irq_d_i`; clear wins. `irq_o` is high when a set status flag is unmasked. A cycle with `stat_rd_i` high clears all flags, and only events in that same cycle survive.
- R14: Status bits 17 and 18 show the current levels of outputs A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_en_i | input | 1 | Count-enable pulse |
| sync_i | input | 1 | Synchronising trigger, resets the count |
| sw_trig_i | input | 1 | Software trigger |
| clk_on_i | input | 1 | Turn channel clock on |
| clk_off_i | input | 1 | Turn channel clock off |
| evt_i | input | 4 | External event candidates, one chosen by mode bits [7:6] |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_d_i | input | 32 | Mode register write data |
| ra_we_i | input | 1 | RA write strobe |
| rb_we_i | input | 1 | RB write strobe |
| rc_we_i | input | 1 | RC write strobe |
| cmp_d_i | input | W | Compare value write data |
| ier_we_i | input | 1 | Mask set strobe |
| idr_we_i | input | 1 | Mask clear strobe |
| irq_d_i | input | 8 | Mask bits to set or clear |
| stat_rd_i | input | 1 | Status read, clears flags |
| count_o | output | W | Current count |
| out_a_o | output | 1 | Waveform output A |
| out_b_o | output | 1 | Waveform output B |
| status_o | output | 19 | Flags [7:0], clock state [16], A [17], B [18] |
| mask_o | output | 8 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal state shows up at the ports one edge after the cycle that changes it.

- A wrong direction bit shows in `count_o` on the next tick: the count steps the wrong way at RC, at 0xFFFF or at 0.
- A stuck halt or clock state freezes `count_o`, and a clock state error also shows in status bit 16.
- A wrong priority or action decode shows in the outputs on the edge after the colliding events.
- A flag or mask error shows in `irq_o` in the cycle after the strobe.

// File: rtl/wave_timer_chan.sv
module wave_timer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en_i,
  input  logic         sync_i,
  input  logic         sw_trig_i,
  input  logic         clk_on_i,
  input  logic         clk_off_i,
  input  logic [3:0]   evt_i,
  input  logic         mode_we_i,
  input  logic [31:0]  mode_d_i,
  input  logic         ra_we_i,
  input  logic         rb_we_i,
  input  logic         rc_we_i,
  input  logic [W-1:0] cmp_d_i,
  input  logic         ier_we_i,
  input  logic         idr_we_i,
  input  logic [7:0]   irq_d_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] count_o,
  output logic         out_a_o,
  output logic         out_b_o,
  output logic [18:0]  status_o,
  output logic [7:0]   mask_o,
  output logic         irq_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [31:0]  mode_q;
  logic [W-1:0] ra_q, rb_q, rc_q, cnt_n, top_v;
  logic         dir_dn, dir_n, clk_on, stopped;
  logic [7:0]   flags;
  logic [3:0]   evt_prev;
  logic [1:0]   act_a, act_b;

  logic [1:0] wsel, edge_sel, src;
  logic       stop_rc, dis_rc, evt_trg_en;
  assign wsel       = mode_q[1:0];
  assign stop_rc    = mode_q[2];
  assign dis_rc     = mode_q[3];
  assign edge_sel   = mode_q[5:4];
  assign src        = mode_q[7:6];
  assign evt_trg_en = mode_q[8];

  logic unused_mode;
  assign unused_mode = ^mode_q[15:9];

  logic ev_now, ev_was, evt, trig, tick, hit_a, hit_b, hit_c, ovf;
  assign ev_now = evt_i[src];
  assign ev_was = evt_prev[src];
  assign evt    = (edge_sel[0] & ev_now & ~ev_was) | (edge_sel[1] & ~ev_now & ev_was);
  assign trig   = sync_i | sw_trig_i | (evt & evt_trg_en);
  assign tick   = cnt_en_i & clk_on & ~stopped;
  assign hit_a  = tick & (count_o == ra_q);
  assign hit_b  = tick & (count_o == rb_q);
  assign hit_c  = tick & (count_o == rc_q);
  assign ovf    = tick & (count_o == MAXV);
  assign top_v  = (wsel == 2'd3) ? rc_q : MAXV;

  always_comb begin
    cnt_n = count_o;
    dir_n = dir_dn;
    if (trig) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (tick) begin
      case (wsel)
        2'd0: cnt_n = count_o + 1'b1;
        2'd2: cnt_n = hit_c ? '0 : count_o + 1'b1;
        default: begin
          if (!dir_dn) begin
            if (count_o == top_v) begin
              dir_n = 1'b1;
              cnt_n = count_o - 1'b1;
            end else begin
              cnt_n = count_o + 1'b1;
            end
          end else if (count_o == '0) begin
            dir_n = 1'b0;
            cnt_n = count_o + 1'b1;
          end else begin
            cnt_n = count_o - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    act_a = 2'd0;
    if (hit_a) act_a = mode_q[17:16];
    if (hit_c && mode_q[19:18] != 2'd0) act_a = mode_q[19:18];
    if (evt && mode_q[21:20] != 2'd0) act_a = mode_q[21:20];
    if (sw_trig_i && mode_q[23:22] != 2'd0) act_a = mode_q[23:22];
    act_b = 2'd0;
    if (hit_b) act_b = mode_q[25:24];
    if (hit_c && mode_q[27:26] != 2'd0) act_b = mode_q[27:26];
    if (evt && mode_q[29:28] != 2'd0) act_b = mode_q[29:28];
    if (sw_trig_i && mode_q[31:30] != 2'd0) act_b = mode_q[31:30];
  end

  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (act)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ra_q     <= '0;
      rb_q     <= '0;
      rc_q     <= '0;
      count_o  <= '0;
      dir_dn   <= 1'b0;
      clk_on   <= 1'b0;
      stopped  <= 1'b0;
      flags    <= '0;
      mask_o   <= '0;
      evt_prev <= '0;
      out_a_o  <= 1'b0;
      out_b_o  <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_d_i;
      if (ra_we_i) ra_q <= cmp_d_i;
      if (rb_we_i) rb_q <= cmp_d_i;
      if (rc_we_i) rc_q <= cmp_d_i;
      count_o  <= cnt_n;
      dir_dn   <= dir_n;
      evt_prev <= evt_i;
      out_a_o  <= apply_act(out_a_o, act_a);
      out_b_o  <= apply_act(out_b_o, act_b);
      if (clk_off_i || (hit_c && dis_rc)) clk_on <= 1'b0;
      else if (clk_on_i)                  clk_on <= 1'b1;
      if (hit_c && stop_rc) stopped <= 1'b1;
      else if (trig)        stopped <= 1'b0;
      flags  <= (stat_rd_i ? 8'h00 : flags) |
                {evt, 2'b00, hit_c, hit_b, hit_a, 1'b0, ovf};
      mask_o <= (mask_o | (ier_we_i ? irq_d_i : 8'h00)) &
                ~(idr_we_i ? irq_d_i : 8'h00);
    end
  end

  assign status_o = {out_b_o, out_a_o, clk_on, 8'h00, flags};
  assign irq_o    = |(flags & mask_o);
endmodule

// File: rtl/wave_timer_chan_chk.sv
module wave_timer_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en_i,
  input logic         sync_i,
  input logic         sw_trig_i,
  input logic         clk_off_i,
  input logic         ier_we_i,
  input logic         idr_we_i,
  input logic [7:0]   irq_d_i,
  input logic         stat_rd_i,
  input logic [W-1:0] count_o,
  input logic         clk_state,
  input logic [7:0]   flag_bits,
  input logic [7:0]   mask_o,
  input logic [1:0]   wsel,
  input logic [1:0]   edge_sel,
  input logic         trg_en,
  input logic         stopped
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !sync_i && !sw_trig_i && !trg_en) |=> $stable(count_o)); // R2
  AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off_i |=> !clk_state); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_state && !stopped && cnt_en_i && wsel == 2'd0 && !sync_i && !sw_trig_i && !trg_en)
    |=> count_o == $past(count_o) + 1'b1); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !cnt_en_i && edge_sel == 2'd0) |=> flag_bits == 8'h00); // R13
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    idr_we_i |=> (mask_o & $past(irq_d_i)) == 8'h00); // R13
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_we_i && !idr_we_i) |=> (mask_o & $past(irq_d_i)) == $past(irq_d_i)); // R13
endmodule

bind wave_timer_chan wave_timer_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .sync_i(sync_i),
  .sw_trig_i(sw_trig_i), .clk_off_i(clk_off_i), .ier_we_i(ier_we_i),
  .idr_we_i(idr_we_i), .irq_d_i(irq_d_i), .stat_rd_i(stat_rd_i),
  .count_o(count_o), .clk_state(status_o[16]), .flag_bits(status_o[7:0]),
  .mask_o(mask_o), .wsel(mode_q[1:0]), .edge_sel(mode_q[5:4]),
  .trg_en(mode_q[8]), .stopped(stopped)
);

// File: tb/tb_wave_timer_chan.sv
`timescale 1ns/1ps
module tb_wave_timer_chan;
  localparam int W = 16;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en_i = 0, sync_i = 0, sw_trig_i = 0, clk_on_i = 0, clk_off_i = 0;
  logic [3:0] evt_i = '0;
  logic mode_we_i = 0;
  logic [31:0] mode_d_i = '0;
  logic ra_we_i = 0, rb_we_i = 0, rc_we_i = 0;
  logic [W-1:0] cmp_d_i = '0;
  logic ier_we_i = 0, idr_we_i = 0;
  logic [7:0] irq_d_i = '0;
  logic stat_rd_i = 0;
  logic [W-1:0] count_o;
  logic out_a_o, out_b_o, irq_o;
  logic [18:0] status_o;
  logic [7:0] mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wave_timer_chan #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .sync_i(sync_i),
    .sw_trig_i(sw_trig_i), .clk_on_i(clk_on_i), .clk_off_i(clk_off_i),
    .evt_i(evt_i), .mode_we_i(mode_we_i), .mode_d_i(mode_d_i),
    .ra_we_i(ra_we_i), .rb_we_i(rb_we_i), .rc_we_i(rc_we_i), .cmp_d_i(cmp_d_i),
    .ier_we_i(ier_we_i), .idr_we_i(idr_we_i), .irq_d_i(irq_d_i),
    .stat_rd_i(stat_rd_i), .count_o(count_o), .out_a_o(out_a_o),
    .out_b_o(out_b_o), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic [31:0] v);
    mode_we_i = 1; mode_d_i = v; @(negedge clk); mode_we_i = 0;
  endtask

  task automatic wr_cmp(input logic [W-1:0] ra, input logic [W-1:0] rb, input logic [W-1:0] rc);
    ra_we_i = 1; cmp_d_i = ra; @(negedge clk); ra_we_i = 0;
    rb_we_i = 1; cmp_d_i = rb; @(negedge clk); rb_we_i = 0;
    rc_we_i = 1; cmp_d_i = rc; @(negedge clk); rc_we_i = 0;
  endtask

  task automatic ticks(input int n);
    cnt_en_i = 1; repeat (n) @(negedge clk); cnt_en_i = 0;
  endtask

  task automatic clock_on();
    clk_on_i = 1; @(negedge clk); clk_on_i = 0;
  endtask

  task automatic pulse_sync();
    sync_i = 1; @(negedge clk); sync_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 outputs", {out_b_o, out_a_o}, 0);
    chk("R1 status", status_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_clock();
    do_reset();
    ticks(3);
    chk("R2 no count while clock off", count_o, 0);
    clock_on();
    chk("R2 clock state bit", status_o[16], 1);
    ticks(5);
    chk("R2 five ticks", count_o, 5);
    repeat (2) @(negedge clk);
    chk("R2 idle holds", count_o, 5);
    clk_on_i = 1; clk_off_i = 1; @(negedge clk); clk_on_i = 0; clk_off_i = 0;
    chk("R2 off wins", status_o[16], 0);
    ticks(2);
    chk("R2 frozen after off", count_o, 5);
    pulse_sync();
    chk("R7 sync zeroes count", count_o, 0);
  endtask

  task automatic t_up_wrap();
    do_reset();
    clock_on();
    ticks(65535);
    chk("R3 reach max", count_o, 16'hFFFF);
    chk("R3 no overflow yet", status_o[0], 0);
    ticks(1);
    chk("R3 wrap to zero", count_o, 0);
    chk("R3 overflow flag", status_o[0], 1);
    stat_rd_i = 1; @(negedge clk); stat_rd_i = 0;
    chk("R13 read clears flags", status_o[7:0], 0);
  endtask

  task automatic t_updown();
    do_reset();
    wr_mode(32'h1);
    clock_on();
    ticks(65535);
    chk("R4 reach max", count_o, 16'hFFFF);
    ticks(1);
    chk("R4 turn at max", count_o, 16'hFFFE);
    chk("R3 overflow at max in mode 1", status_o[0], 1);
    ticks(1);
    chk("R4 keeps going down", count_o, 16'hFFFD);
    pulse_sync();
    ticks(1);
    chk("R7 direction up after trigger", count_o, 1);
  endtask

  task automatic t_auto();
    do_reset();
    wr_mode(32'h2);
    wr_cmp(16'd9, 16'd9, 16'd4);
    clock_on();
    ticks(5);
    chk("R5 restart at RC", count_o, 0);
    chk("R8 RC flag", status_o[4], 1);
    ticks(2);
    chk("R5 counts on after restart", count_o, 2);
  endtask

  task automatic t_updown_rc();
    do_reset();
    wr_mode(32'h3);
    wr_cmp(16'd9, 16'd9, 16'd3);
    clock_on();
    ticks(4);
    chk("R6 turn at RC", count_o, 2);
    ticks(2);
    chk("R6 reach zero", count_o, 0);
    ticks(1);
    chk("R6 turn at zero", count_o, 1);
    ticks(1);
    chk("R6 up after zero", count_o, 2);
  endtask

  task automatic t_stop_dis();
    do_reset();
    wr_mode(32'h4);
    wr_cmp(16'd9, 16'd9, 16'd2);
    clock_on();
    ticks(3);
    chk("R12 step past RC", count_o, 3);
    ticks(3);
    chk("R12 halted", count_o, 3);
    chk("R12 clock still on", status_o[16], 1);
    sw_trig_i = 1; @(negedge clk); sw_trig_i = 0;
    chk("R7 sw trigger zeroes", count_o, 0);
    ticks(1);
    chk("R7 halt released", count_o, 1);
    wr_mode(32'h8);
    wr_cmp(16'd9, 16'd9, 16'd3);
    ticks(3);
    chk("R12 disable step", count_o, 4);
    chk("R12 clock turned off", status_o[16], 0);
    ticks(2);
    chk("R12 no count after disable", count_o, 4);
  endtask

  task automatic t_actions();
    do_reset();
    wr_mode((32'd1 << 16) | (32'd2 << 18) | (32'd3 << 24) | (32'd1 << 26));
    wr_cmp(16'd1, 16'd2, 16'd3);
    clock_on();
    ticks(2);
    chk("R9 RA set on A", out_a_o, 1);
    chk("R8 RA flag", status_o[2], 1);
    chk("R14 mirrors A=1 B=0", status_o[18:17], 2'b01);
    ticks(1);
    chk("R9 RB toggle on B", out_b_o, 1);
    ticks(1);
    chk("R9 RC clear on A", out_a_o, 0);
    chk("R9 RC set keeps B", out_b_o, 1);
    chk("R8 compare flags", status_o[4:2], 3'b111);
    chk("R14 mirrors A=0 B=1", status_o[18:17], 2'b10);
    pulse_sync();
    ticks(3);
    chk("R9 toggle back B", out_b_o, 0);
    chk("R9 set again A", out_a_o, 1);
  endtask

  task automatic t_priority();
    do_reset();
    wr_mode((32'd3 << 16) | (32'd2 << 18) | (32'd1 << 22));
    wr_cmp(16'd0, 16'd0, 16'd0);
    clock_on();
    ticks(1);
    chk("R10 RC over RA", out_a_o, 0);
    chk("R9 none leaves B", out_b_o, 0);
    pulse_sync();
    cnt_en_i = 1; sw_trig_i = 1; @(negedge clk); cnt_en_i = 0; sw_trig_i = 0;
    chk("R10 sw trigger over RC", out_a_o, 1);
    chk("R7 sw trigger beats tick", count_o, 0);
  endtask

  task automatic t_event();
    do_reset();
    wr_mode(32'h1A0 | (32'd3 << 20));
    clock_on();
    ticks(5);
    evt_i[2] = 1'b1; @(negedge clk);
    chk("R11 rising edge ignored A", out_a_o, 0);
    chk("R11 rising edge ignored count", count_o, 5);
    evt_i[0] = 1'b1; @(negedge clk); evt_i[0] = 1'b0; @(negedge clk);
    chk("R11 other source ignored", out_a_o, 0);
    evt_i[2] = 1'b0; @(negedge clk);
    chk("R11 falling edge toggles A", out_a_o, 1);
    chk("R7 event trigger zeroes", count_o, 0);
    chk("R11 event flag", status_o[7], 1);
    wr_mode(32'h0A0 | (32'd3 << 20));
    ticks(3);
    evt_i[2] = 1'b1; @(negedge clk); evt_i[2] = 1'b0; @(negedge clk);
    chk("R11 event toggles A again", out_a_o, 0);
    chk("R7 event without enable keeps count", count_o, 3);
  endtask

  task automatic t_irq();
    do_reset();
    wr_cmp(16'd9, 16'd9, 16'd1);
    clock_on();
    ticks(2);
    chk("R13 masked flag no irq", irq_o, 0);
    ier_we_i = 1; irq_d_i = 8'h10; @(negedge clk); ier_we_i = 0;
    chk("R13 mask set", mask_o, 8'h10);
    chk("R13 irq on unmask", irq_o, 1);
    idr_we_i = 1; @(negedge clk); idr_we_i = 0;
    chk("R13 mask cleared", mask_o, 8'h00);
    chk("R13 irq off", irq_o, 0);
    ier_we_i = 1; @(negedge clk); ier_we_i = 0;
    stat_rd_i = 1; @(negedge clk); stat_rd_i = 0;
    chk("R13 read drops irq", irq_o, 0);
    chk("R13 flags cleared", status_o[7:0], 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", WD);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clock();
    t_auto();
    t_updown_rc();
    t_stop_dis();
    t_actions();
    t_priority();
    t_event();
    t_irq();
    t_up_wrap();
    t_updown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule